// File: doc/BRIEF.md
# Alignment Fault Entry Sequencer

This unit performs the architectural bookkeeping a 32-bit processor needs when an instruction takes an alignment-class fault. Fault detection happens elsewhere. When the pipeline offers a fault on the request channel, the unit does two things:

- It squashes the offending instruction in that same cycle.
- On the accepting clock edge it captures the return instruction address, the old machine-state word and the operand address. It also produces a filtered machine-state word and a redirect fetch target.

The filtered machine-state word clears every bit except three enable bits, whose positions are parameters. Those keep their old values. The redirect target joins the upper half of the vector base register to a twelve-bit slice of the vector offset register, with four zero bits at the bottom.

The request side is a valid/ready channel. `flt_ready` is high whenever no redirect is being issued. The producer must hold `flt_valid` and its data until it sees ready high at a clock edge. A request is accepted only on a cycle where both are high. The outputs carry no back-pressure: the redirect and the machine-state load are single-cycle pulses that the consumer must take.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `srr0_q`, `srr1_q`, `dear_q`, `msr_next` and `redir_pc` are zero, `redir_valid` and `msr_load` are low, and `flt_ready` is high.
- R2: `squash` is high in exactly the cycles where `flt_valid` and `flt_ready` are both high (combinational, same cycle).
- R3: After an accepting edge, `srr0_q` holds the `flt_iaddr` value that was present at that edge.
- R4: After an accepting edge, `srr1_q` holds the complete `msr_cur` word that was present at that edge.
- R5: After an accepting edge, `msr_next` equals the old `msr_cur` ANDed with a mask in which only bits 17, 12 and 9 are set (mask 0x00021200); every other bit is zero.
- R6: After an accepting edge, `dear_q` holds the `flt_daddr` value that was present at that edge.
- R7: After an accepting edge, `redir_pc` equals {`vec_base`[31:16], `vec_ofs`[15:4], 4'b0000}; all other bits of the vector registers are ignored.
- R8: `redir_valid` and `msr_load` rise for exactly one cycle after each accepting edge.
- R9: While `redir_valid` is high, `flt_ready` is low, so a request held in that cycle is not squashed and changes no saved register.
- R10: With no accepted request, `srr0_q`, `srr1_q`, `dear_q`, `msr_next` and `redir_pc` keep their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault request valid |
| flt_ready | output | 1 | Unit can accept a fault this cycle |
| flt_iaddr | input | 32 | Effective address of the faulting instruction |
| flt_daddr | input | 32 | Operand effective address computed by that instruction |
| msr_cur | input | 32 | Machine-state word before entry |
| vec_base | input | 32 | Vector base (prefix) register |
| vec_ofs | input | 32 | Vector offset register for the alignment class |
| squash | output | 1 | Suppress the faulting instruction (same cycle as acceptance) |
| srr0_q | output | 32 | Saved return address |
| srr1_q | output | 32 | Saved machine-state word |
| dear_q | output | 32 | Recorded operand address |
| msr_load | output | 1 | One-cycle strobe to load `msr_next` into the machine state |
| msr_next | output | 32 | Filtered machine-state word |
| redir_valid | output | 1 | One-cycle fetch redirect strobe |
| redir_pc | output | 32 | New fetch address |

## Verification
The bench drives several kinds of machine-state word:
- all ones and all zeros;
- only the preserved bits set;
- everything except the preserved bits set.

A filter that kept a wrong bit, or cleared a preserved one, shows up as a wrong `msr_next`. Vector offset values with both low and high stray bits set expose a redirect that slices the wrong field or drops the zero nibble. A request held through the redirect cycle carries new data. A unit that ignored its own ready would squash a second time and overwrite the saved registers with that data. Idle cycles with changing inputs catch registers that load without a request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  parameter int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t ret_pc;
    word_t old_msr;
    word_t data_ea;
    word_t new_msr;
    word_t tgt_pc;
  } entry_snap_t;
endpackage

// File: rtl/exc_msr_filter.sv
module exc_msr_filter
  import exc_entry_pkg::*;
#(
  parameter int NKEEP = 3,
  parameter int KEEP_POS [NKEEP] = '{17, 12, 9}
) (
  input  word_t msr_old,
  output word_t msr_filt
);
  logic [NKEEP-1:0][WORD_W-1:0] bit_sel;
  word_t keep_mask;

  for (genvar g = 0; g < NKEEP; g++) begin : g_keep
    assign bit_sel[g] = {{(WORD_W-1){1'b0}}, 1'b1} << KEEP_POS[g];
  end

  always_comb begin
    keep_mask = '0;
    for (int k = 0; k < NKEEP; k++) keep_mask = keep_mask | bit_sel[k];
  end

  assign msr_filt = msr_old & keep_mask;
endmodule

// File: rtl/exc_vec_target.sv
module exc_vec_target
  import exc_entry_pkg::*;
#(
  parameter int PFX_W   = 16,
  parameter int OFS_LSB = 4,
  parameter int OFS_W   = 12
) (
  input  word_t base_reg,
  input  word_t ofs_reg,
  output word_t target
);
  localparam int ZW = WORD_W - PFX_W - OFS_W;

  logic [PFX_W-1:0] pfx;
  logic [OFS_W-1:0] ofs;

  assign pfx    = base_reg[WORD_W-1 -: PFX_W];
  assign ofs    = ofs_reg[OFS_LSB +: OFS_W];
  assign target = {pfx, ofs, {ZW{1'b0}}};
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  entry_snap_t snap_d,
  output entry_snap_t snap_q,
  output logic        pulse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= load;
      if (load) snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int PFX_W   = 16,
  parameter int OFS_LSB = 4,
  parameter int OFS_W   = 12,
  parameter int NKEEP   = 3,
  parameter int KEEP_POS [NKEEP] = '{17, 12, 9}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [WORD_W-1:0] flt_iaddr,
  input  logic [WORD_W-1:0] flt_daddr,
  input  logic [WORD_W-1:0] msr_cur,
  input  logic [WORD_W-1:0] vec_base,
  input  logic [WORD_W-1:0] vec_ofs,
  output logic              squash,
  output logic [WORD_W-1:0] srr0_q,
  output logic [WORD_W-1:0] srr1_q,
  output logic [WORD_W-1:0] dear_q,
  output logic              msr_load,
  output logic [WORD_W-1:0] msr_next,
  output logic              redir_valid,
  output logic [WORD_W-1:0] redir_pc
);
  word_t       filt_msr;
  word_t       tgt;
  entry_snap_t snap_d;
  entry_snap_t snap_q;
  logic        pulse;
  logic        accept;

  exc_msr_filter #(.NKEEP(NKEEP), .KEEP_POS(KEEP_POS)) u_filt (
    .msr_old (msr_cur),
    .msr_filt(filt_msr)
  );

  exc_vec_target #(.PFX_W(PFX_W), .OFS_LSB(OFS_LSB), .OFS_W(OFS_W)) u_vec (
    .base_reg(vec_base),
    .ofs_reg (vec_ofs),
    .target  (tgt)
  );

  // one bubble after every accept: redirect cycle blocks new requests
  assign flt_ready = ~pulse;
  assign accept    = flt_valid & flt_ready;
  assign squash    = accept;

  always_comb begin
    snap_d.ret_pc  = flt_iaddr;
    snap_d.old_msr = msr_cur;
    snap_d.data_ea = flt_daddr;
    snap_d.new_msr = filt_msr;
    snap_d.tgt_pc  = tgt;
  end

  exc_entry_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .snap_d (snap_d),
    .snap_q (snap_q),
    .pulse_q(pulse)
  );

  assign srr0_q      = snap_q.ret_pc;
  assign srr1_q      = snap_q.old_msr;
  assign dear_q      = snap_q.data_ea;
  assign msr_next    = snap_q.new_msr;
  assign redir_pc    = snap_q.tgt_pc;
  assign redir_valid = pulse;
  assign msr_load    = pulse;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int ZW    = 4,
  parameter int NKEEP = 3,
  parameter int KEEP_POS [NKEEP] = '{17, 12, 9}
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_valid,
  input logic              flt_ready,
  input logic [WORD_W-1:0] flt_iaddr,
  input logic [WORD_W-1:0] flt_daddr,
  input logic [WORD_W-1:0] msr_cur,
  input logic              squash,
  input logic [WORD_W-1:0] srr0_q,
  input logic [WORD_W-1:0] srr1_q,
  input logic [WORD_W-1:0] dear_q,
  input logic [WORD_W-1:0] msr_next,
  input logic              redir_valid,
  input logic [WORD_W-1:0] redir_pc
);
  word_t keep_m;
  always_comb begin
    keep_m = '0;
    for (int k = 0; k < NKEEP; k++) keep_m[KEEP_POS[k]] = 1'b1;
  end

  a_r2_squash_leads_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> redir_valid);
  a_r3_ret_pc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> srr0_q == $past(flt_iaddr));
  a_r4_msr_saved: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> srr1_q == $past(msr_cur));
  a_r5_msr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> ((msr_next & ~keep_m) == '0) && ((msr_next & keep_m) == ($past(msr_cur) & keep_m)));
  a_r6_data_ea_saved: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> dear_q == $past(flt_daddr));
  a_r7_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> redir_pc[ZW-1:0] == '0);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);
  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !flt_ready && !squash);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !squash |=> $stable(srr0_q) && $stable(srr1_q) && $stable(dear_q) && $stable(redir_pc));
endmodule

bind exc_entry_unit exc_entry_chk #(
  .ZW(WORD_W - PFX_W - OFS_W), .NKEEP(NKEEP), .KEEP_POS(KEEP_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
  .flt_iaddr(flt_iaddr), .flt_daddr(flt_daddr), .msr_cur(msr_cur),
  .squash(squash), .srr0_q(srr0_q), .srr1_q(srr1_q), .dear_q(dear_q),
  .msr_next(msr_next), .redir_valid(redir_valid), .redir_pc(redir_pc)
);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_valid = 1'b0;
  logic flt_ready, squash, msr_load, redir_valid;
  logic [31:0] flt_iaddr = '0, flt_daddr = '0, msr_cur = '0, vec_base = '0, vec_ofs = '0;
  logic [31:0] srr0_q, srr1_q, dear_q, msr_next, redir_pc;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
    .flt_iaddr(flt_iaddr), .flt_daddr(flt_daddr), .msr_cur(msr_cur),
    .vec_base(vec_base), .vec_ofs(vec_ofs), .squash(squash),
    .srr0_q(srr0_q), .srr1_q(srr1_q), .dear_q(dear_q), .msr_load(msr_load),
    .msr_next(msr_next), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  // {iaddr, daddr, msr, vec_base, vec_ofs}
  localparam logic [159:0] VEC [6] = '{
    {32'h0000_1004, 32'h0000_2003, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0120},
    {32'h8000_0010, 32'h1234_5671, 32'h0000_0000, 32'h1234_ABCD, 32'hFFFF_FFFF},
    {32'hDEAD_BEE0, 32'h0000_000E, 32'h0002_1200, 32'hC000_0000, 32'h0000_000F},
    {32'h0000_0000, 32'hFFFF_FFFD, 32'hFFFD_EDFF, 32'h0001_0000, 32'h0000_FFF0},
    {32'h7FFF_FFFC, 32'hA5A5_A5A7, 32'h0002_0000, 32'hFFFF_FFFF, 32'hABCD_1230},
    {32'h0040_0100, 32'h0040_8002, 32'h0000_1A00, 32'h00AB_0000, 32'h0000_0800}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] exp_msr, exp_pc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 srr0", srr0_q, 32'h0);
    chk("R1 srr1", srr1_q, 32'h0);
    chk("R1 dear", dear_q, 32'h0);
    chk("R1 msr_next", msr_next, 32'h0);
    chk("R1 redir_pc", redir_pc, 32'h0);
    chk("R1 strobes", {29'd0, redir_valid, msr_load, flt_ready}, 32'h1);

    for (int v = 0; v < 6; v++) begin
      {flt_iaddr, flt_daddr, msr_cur, vec_base, vec_ofs} = VEC[v];
      exp_msr = VEC[v][95:64] & 32'h0002_1200;
      exp_pc  = {VEC[v][63:48], VEC[v][15:4], 4'b0000};
      flt_valid = 1'b1;
      #1;
      chk("R2 squash on accept", {31'd0, squash}, 32'h1);
      @(negedge clk);
      chk("R3 srr0", srr0_q, VEC[v][159:128]);
      chk("R4 srr1", srr1_q, VEC[v][95:64]);
      chk("R5 msr_next", msr_next, exp_msr);
      chk("R6 dear", dear_q, VEC[v][127:96]);
      chk("R7 redir_pc", redir_pc, exp_pc);
      chk("R8 pulses high", {30'd0, redir_valid, msr_load}, 32'h3);
      // R9 hold a different request during the redirect cycle
      flt_iaddr = ~VEC[v][159:128];
      flt_daddr = ~VEC[v][127:96];
      msr_cur   = ~VEC[v][95:64];
      vec_base  = ~VEC[v][63:32];
      #1;
      chk("R9 ready low", {31'd0, flt_ready}, 32'h0);
      chk("R9 no squash", {31'd0, squash}, 32'h0);
      @(negedge clk);
      flt_valid = 1'b0;
      chk("R8 pulses low", {30'd0, redir_valid, msr_load}, 32'h0);
      chk("R9 srr0 kept", srr0_q, VEC[v][159:128]);
      chk("R9 srr1 kept", srr1_q, VEC[v][95:64]);
      chk("R9 dear kept", dear_q, VEC[v][127:96]);
      chk("R9 redir_pc kept", redir_pc, exp_pc);
      @(negedge clk);
    end

    // R10 idle cycles with moving inputs
    exp_msr = VEC[5][95:64] & 32'h0002_1200;
    for (int i = 0; i < 4; i++) begin
      flt_iaddr = 32'h1111_0000 + i;
      flt_daddr = 32'h2222_0000 + i;
      msr_cur   = 32'hFFFF_FFFF - i;
      vec_base  = 32'h3333_0000 + i;
      vec_ofs   = 32'h0000_4440 + i;
      @(negedge clk);
      chk("R10 idle squash", {31'd0, squash}, 32'h0);
      chk("R10 srr0 hold", srr0_q, VEC[5][159:128]);
      chk("R10 msr_next hold", msr_next, exp_msr);
      chk("R10 no redirect", {31'd0, redir_valid}, 32'h0);
    end

    // R1 reset clears state mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 srr0 after reset", srr0_q, 32'h0);
    chk("R1 ready after reset", {31'd0, flt_ready}, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule